// File: doc/BRIEF.md
# Dual-Plane 1bpp Pixel Packer

The block takes a stream of 2-bit palette indices, one pixel per accepted transfer, and turns each display line into packed 1-bit-per-pixel bytes for two separate planes. Plane A is emitted line by line as soon as each line is packed. Plane B is written into a frame-sized side memory. It is replayed only after the last byte of plane A for the whole frame has left the block. A one-plane mode routes the low index bit to plane A and skips plane B entirely.

Each line is packed into one of two line banks, selected by the parity of the line number. The packer can fill one bank while the other drains. The upstream can also request a blank line at the start of any line. The block then generates the whole line itself with index 3, so both plane bits are 1. A frame is a fixed number of lines, given by a parameter. The mode input may change only between frames, when no frame is in progress.

The fill side has three states:
- FILL_PIX: accepts pixels.
- FILL_BLANK: generates a blank line.
- FILL_HOLD: after the last line of a two-plane frame, waits for the plane-B replay to finish.

Fill transitions:
- blank-take: FILL_PIX to FILL_BLANK.
- blank-end: FILL_BLANK back to FILL_PIX, or to FILL_HOLD on the last line of a two-plane frame.
- frame-held: FILL_PIX to FILL_HOLD on the last pixel of a two-plane frame.
- replay-done: FILL_HOLD to FILL_PIX.

The drain side has three states:
- DRN_IDLE: waits for a full bank.
- DRN_LINE: streams one plane-A line.
- DRN_SIDE: replays plane B.

Drain transitions:
- bank-ready: DRN_IDLE to DRN_LINE.
- line-sent: DRN_LINE to DRN_IDLE.
- plane-a-done: DRN_LINE to DRN_SIDE, in two-plane mode only.
- side-done: DRN_SIDE to DRN_IDLE.

Top module: `dual_plane_packer`

## Requirements
- R1: After reset, out_valid is 0, blank_ack is 0 and pix_ready is 1.
- R2: Pixel x of a line goes to byte x/8 at bit position 7-(x mod 8), so the first pixel of each byte is the MSB. Bit positions past the end of the line in the last byte of a line are 0.
- R3: When two_plane=1, index bit 1 drives the plane-A bit and index bit 0 drives the plane-B bit.
- R4: When two_plane=0, index bit 0 drives the plane-A bit, and no plane-B bytes are emitted.
- R5: Exactly ceil(LINE_PX/8) bytes are emitted per line per plane, and nothing more follows the end of the frame. Line bank storage is sized to the width rounded up to 32 pixels.
- R6: Every plane-A byte of a frame (out_plane=0) is emitted before any plane-B byte (out_plane=1). out_last is 1 with the final byte of plane A and with the final byte of plane B.
- R7: Two line banks alternate by line parity. A second line is accepted while the first is still undrained. pix_ready goes to 0 while both banks hold undrained lines.
- R8: While out_valid=1 and out_ready=0, out_valid, out_data, out_plane and out_last hold their values into the next cycle.
- R9: A blank_req seen at the start of a line takes priority over pix_valid. blank_ack pulses for one cycle with pix_ready=0, and the line is packed as index 3 for every pixel.
- R10: When the drain is idle, the first byte of a line is valid in the cycle after the second rising edge that follows the acceptance of the line's last pixel.
- R11: In two-plane mode, pix_ready stays 0 after the last pixel of a frame until the final plane-B byte is taken. It is 1 again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_plane | input | 1 | 1 = two-plane mode, 0 = one-plane mode; changed only between frames |
| pix_valid | input | 1 | Pixel index valid |
| pix_ready | output | 1 | Packer accepts a pixel this cycle |
| pix_data | input | 2 | Palette index of the pixel |
| blank_req | input | 1 | Request a blank line at the start of a line |
| blank_ack | output | 1 | One-cycle acceptance of a blank line |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Packed byte, MSB = first pixel |
| out_plane | output | 1 | 0 = plane A, 1 = plane B |
| out_last | output | 1 | Final byte of the current plane |

## Verification
Handshakes commit on the rising edge after the bench drives inputs at the falling edge. The bench samples ready and valid one time step later, so every acceptance and every captured byte belongs to the coming edge.

The line latency of R10 is checked as two edges: out_valid must still be 0 one cycle after the last pixel's edge, and 1 with the correct first byte one cycle later. Pixel stalls (R7) and the hold after a two-plane frame (R11) are checked in the same cycle-aligned samples. The resumption of pix_ready is checked in the cycle after the last plane-B byte is taken. Output hold (R8) compares each sample with the previous one whenever the previous cycle was stalled.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

    typedef enum logic [1:0] {
        FILL_PIX   = 2'd0,
        FILL_BLANK = 2'd1,
        FILL_HOLD  = 2'd2
    } fill_state_t;

    typedef enum logic [1:0] {
        DRN_IDLE = 2'd0,
        DRN_LINE = 2'd1,
        DRN_SIDE = 2'd2
    } drain_state_t;

    function automatic int unsigned bytes_per_line(input int unsigned px);
        return (px + 7) / 8;
    endfunction

    function automatic int unsigned bank_stride(input int unsigned px);
        return ((px + 31) / 32) * 4;
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dpp_byte_ram.sv
module dpp_byte_ram #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dpp_fill.sv
module dpp_fill
    import dpp_pkg::*;
#(
    parameter int unsigned LINE_PX     = 44,
    parameter int unsigned FRAME_LINES = 4,
    localparam int unsigned EMIT   = bytes_per_line(LINE_PX),
    localparam int unsigned STRIDE = bank_stride(LINE_PX),
    localparam int unsigned XW     = width_of(LINE_PX),
    localparam int unsigned LW     = width_of(FRAME_LINES),
    localparam int unsigned LAW    = width_of(2 * STRIDE),
    localparam int unsigned SAW    = width_of(FRAME_LINES * EMIT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           two_plane,
    input  logic           pix_valid,
    input  logic [1:0]     pix_data,
    input  logic           blank_req,
    input  logic           clr_en,
    input  logic           clr_bank,
    input  logic           frame_done,
    output logic           pix_ready,
    output logic           blank_ack,
    output logic [1:0]     bank_full,
    output logic           la_we,
    output logic [LAW-1:0] la_addr,
    output logic [7:0]     la_data,
    output logic           sb_we,
    output logic [SAW-1:0] sb_addr,
    output logic [7:0]     sb_data
);

    localparam logic [XW-1:0] PX_LAST   = XW'(LINE_PX - 1);
    localparam logic [LW-1:0] LINE_LAST = LW'(FRAME_LINES - 1);

    fill_state_t   state, state_n;
    logic [XW-1:0] px;
    logic [LW-1:0] line;
    logic [7:0]    acc   [2];
    logic [7:0]    acc_n [2];
    logic [1:0]    pbit;
    logic [1:0]    full_n;
    logic [1:0]    val;
    logic [2:0]    bitpos;
    logic          bank, at_start, take_blank, step, last_px, last_line, byte_end;

    assign bank      = line[0];
    assign at_start  = (px == '0);
    assign last_px   = (px == PX_LAST);
    assign last_line = (line == LINE_LAST);
    assign byte_end  = (px[2:0] == 3'd7) || last_px;
    assign bitpos    = 3'd7 - px[2:0];
    assign val       = (state == FILL_BLANK) ? 2'b11 : pix_data;

    // Outputs and handshake decode
    always_comb begin
        take_blank = 1'b0;
        pix_ready  = 1'b0;
        unique case (state)
            FILL_PIX: begin
                take_blank = at_start && blank_req && !bank_full[bank];
                pix_ready  = !bank_full[bank] && !(at_start && blank_req);
            end
            FILL_BLANK: pix_ready = 1'b0;
            FILL_HOLD:  pix_ready = 1'b0;
            default:    pix_ready = 1'b0;
        endcase
    end

    assign blank_ack = take_blank;
    assign step      = (pix_valid && pix_ready) || (state == FILL_BLANK);

    // Plane bit routing: plane 0 is A, plane 1 is B
    assign pbit[0] = two_plane ? val[1] : val[0];
    assign pbit[1] = val[0];

    for (genvar p = 0; p < 2; p++) begin : g_plane
        assign acc_n[p] = acc[p] | ({7'b0, pbit[p]} << bitpos);
    end

    assign la_we   = step && byte_end;
    assign la_addr = LAW'(int'(bank) * STRIDE) + LAW'(px >> 3);
    assign la_data = acc_n[0];
    assign sb_we   = step && byte_end && two_plane;
    assign sb_addr = SAW'(int'(line) * EMIT) + SAW'(px >> 3);
    assign sb_data = acc_n[1];

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            FILL_PIX: begin
                if (take_blank) begin
                    state_n = FILL_BLANK;
                end else if (step && last_px && last_line && two_plane) begin
                    state_n = FILL_HOLD;
                end
            end
            FILL_BLANK: begin
                if (last_px) begin
                    state_n = (last_line && two_plane) ? FILL_HOLD : FILL_PIX;
                end
            end
            FILL_HOLD: begin
                if (frame_done) begin
                    state_n = FILL_PIX;
                end
            end
            default: state_n = FILL_PIX;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FILL_PIX;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        full_n = bank_full;
        if (step && last_px) begin
            full_n[bank] = 1'b1;
        end
        if (clr_en) begin
            full_n[clr_bank] = 1'b0;
        end
    end

    // Counters, accumulators and bank flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px        <= '0;
            line      <= '0;
            acc[0]    <= '0;
            acc[1]    <= '0;
            bank_full <= '0;
        end else begin
            bank_full <= full_n;
            if (step) begin
                px <= last_px ? '0 : px + 1'b1;
                if (last_px) begin
                    line <= last_line ? '0 : line + 1'b1;
                end
                acc[0] <= byte_end ? 8'h00 : acc_n[0];
                acc[1] <= byte_end ? 8'h00 : acc_n[1];
            end
        end
    end

    p_clear_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> bank_full[clr_bank]);

    p_done_in_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && two_plane) |-> (state == FILL_HOLD));

    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        blank_ack |=> (!blank_ack && !pix_ready));

endmodule

// File: rtl/dpp_drain.sv
module dpp_drain
    import dpp_pkg::*;
#(
    parameter int unsigned LINE_PX     = 44,
    parameter int unsigned FRAME_LINES = 4,
    localparam int unsigned EMIT   = bytes_per_line(LINE_PX),
    localparam int unsigned STRIDE = bank_stride(LINE_PX),
    localparam int unsigned SIDE   = FRAME_LINES * EMIT,
    localparam int unsigned IW     = width_of(EMIT),
    localparam int unsigned LW     = width_of(FRAME_LINES),
    localparam int unsigned LAW    = width_of(2 * STRIDE),
    localparam int unsigned SAW    = width_of(SIDE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           two_plane,
    input  logic [1:0]     bank_full,
    input  logic           out_ready,
    input  logic [7:0]     la_rdata,
    input  logic [7:0]     sb_rdata,
    output logic [LAW-1:0] la_raddr,
    output logic [SAW-1:0] sb_raddr,
    output logic           out_valid,
    output logic [7:0]     out_data,
    output logic           out_plane,
    output logic           out_last,
    output logic           clr_en,
    output logic           clr_bank,
    output logic           frame_done
);

    localparam logic [IW-1:0]  IDX_LAST  = IW'(EMIT - 1);
    localparam logic [LW-1:0]  LINE_LAST = LW'(FRAME_LINES - 1);
    localparam logic [SAW-1:0] SIDE_LAST = SAW'(SIDE - 1);

    drain_state_t   state, state_n;
    logic [IW-1:0]  idx;
    logic [LW-1:0]  dline;
    logic [SAW-1:0] sidx;
    logic           dbank, fire, line_end, last_line, side_end;

    assign dbank     = dline[0];
    assign line_end  = (idx == IDX_LAST);
    assign last_line = (dline == LINE_LAST);
    assign side_end  = (sidx == SIDE_LAST);
    assign la_raddr  = LAW'(int'(dbank) * STRIDE) + LAW'(idx);
    assign sb_raddr  = sidx;
    assign fire      = out_valid && out_ready;
    assign clr_bank  = dbank;

    // Outputs
    always_comb begin
        out_valid  = 1'b0;
        out_plane  = 1'b0;
        out_data   = la_rdata;
        out_last   = 1'b0;
        clr_en     = 1'b0;
        frame_done = 1'b0;
        unique case (state)
            DRN_IDLE: out_valid = 1'b0;
            DRN_LINE: begin
                out_valid  = 1'b1;
                out_last   = line_end && last_line;
                clr_en     = out_ready && line_end;
                frame_done = out_ready && line_end && last_line && !two_plane;
            end
            DRN_SIDE: begin
                out_valid  = 1'b1;
                out_plane  = 1'b1;
                out_data   = sb_rdata;
                out_last   = side_end;
                frame_done = out_ready && side_end;
            end
            default: out_valid = 1'b0;
        endcase
    end

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            DRN_IDLE: begin
                if (bank_full[dbank]) begin
                    state_n = DRN_LINE;
                end
            end
            DRN_LINE: begin
                if (fire && line_end) begin
                    state_n = (last_line && two_plane) ? DRN_SIDE : DRN_IDLE;
                end
            end
            DRN_SIDE: begin
                if (fire && side_end) begin
                    state_n = DRN_IDLE;
                end
            end
            default: state_n = DRN_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DRN_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            dline <= '0;
            sidx  <= '0;
        end else begin
            if (state == DRN_LINE && fire) begin
                idx <= line_end ? '0 : idx + 1'b1;
                if (line_end) begin
                    dline <= last_line ? '0 : dline + 1'b1;
                end
            end
            if (state == DRN_SIDE && fire) begin
                sidx <= side_end ? '0 : sidx + 1'b1;
            end
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_plane) && $stable(out_last)));

    p_plane_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_plane) |-> $past(out_valid && out_ready && out_last));

    p_line_needs_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DRN_LINE) |-> bank_full[dbank]);

endmodule

// File: rtl/dual_plane_packer.sv
module dual_plane_packer
    import dpp_pkg::*;
#(
    parameter int unsigned LINE_PX     = 44,
    parameter int unsigned FRAME_LINES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       two_plane,
    input  logic       pix_valid,
    output logic       pix_ready,
    input  logic [1:0] pix_data,
    input  logic       blank_req,
    output logic       blank_ack,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_plane,
    output logic       out_last
);

    localparam int unsigned EMIT   = bytes_per_line(LINE_PX);
    localparam int unsigned STRIDE = bank_stride(LINE_PX);
    localparam int unsigned SIDE   = FRAME_LINES * EMIT;
    localparam int unsigned LAW    = width_of(2 * STRIDE);
    localparam int unsigned SAW    = width_of(SIDE);

    logic [1:0]     bank_full;
    logic           clr_en, clr_bank, frame_done;
    logic           la_we, sb_we;
    logic [LAW-1:0] la_waddr, la_raddr;
    logic [SAW-1:0] sb_waddr, sb_raddr;
    logic [7:0]     la_wdata, sb_wdata, la_rdata, sb_rdata;

    dpp_fill #(.LINE_PX(LINE_PX), .FRAME_LINES(FRAME_LINES)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .two_plane  (two_plane),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .blank_req  (blank_req),
        .clr_en     (clr_en),
        .clr_bank   (clr_bank),
        .frame_done (frame_done),
        .pix_ready  (pix_ready),
        .blank_ack  (blank_ack),
        .bank_full  (bank_full),
        .la_we      (la_we),
        .la_addr    (la_waddr),
        .la_data    (la_wdata),
        .sb_we      (sb_we),
        .sb_addr    (sb_waddr),
        .sb_data    (sb_wdata)
    );

    dpp_byte_ram #(.DEPTH(2 * STRIDE)) u_line_banks (
        .clk   (clk),
        .we    (la_we),
        .waddr (la_waddr),
        .wdata (la_wdata),
        .raddr (la_raddr),
        .rdata (la_rdata)
    );

    dpp_byte_ram #(.DEPTH(SIDE)) u_side_mem (
        .clk   (clk),
        .we    (sb_we),
        .waddr (sb_waddr),
        .wdata (sb_wdata),
        .raddr (sb_raddr),
        .rdata (sb_rdata)
    );

    dpp_drain #(.LINE_PX(LINE_PX), .FRAME_LINES(FRAME_LINES)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .two_plane  (two_plane),
        .bank_full  (bank_full),
        .out_ready  (out_ready),
        .la_rdata   (la_rdata),
        .sb_rdata   (sb_rdata),
        .la_raddr   (la_raddr),
        .sb_raddr   (sb_raddr),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_plane  (out_plane),
        .out_last   (out_last),
        .clr_en     (clr_en),
        .clr_bank   (clr_bank),
        .frame_done (frame_done)
    );

    p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

endmodule

// File: tb/sim_dual_plane_packer.sv
module sim_dual_plane_packer;

    localparam int W    = 44;
    localparam int H    = 4;
    localparam int EMIT = (W + 7) / 8;
    localparam int PB   = H * EMIT;

    // [15:8] expected byte total, [7] two_plane, [6] random ready,
    // [5:4] pattern kind, [3:0] blank-line mask
    localparam logic [15:0] VEC [6] = '{
        16'h3080, 16'h30D5, 16'h1840, 16'h1838, 16'h30EF, 16'h30F2
    };

    logic clk = 1'b0;
    logic rst_n, two_plane, pix_valid, pix_ready, blank_req, blank_ack;
    logic out_valid, out_ready, out_plane, out_last;
    logic [1:0] pix_data;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit wd_hit = 1'b0;

    logic [7:0] cap_data [64];
    logic       cap_plane[64];
    logic       cap_last [64];
    int         cap_n;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) wd_hit <= 1'b1;
    end

    dual_plane_packer #(.LINE_PX(W), .FRAME_LINES(H)) u0 (
        .clk(clk), .rst_n(rst_n), .two_plane(two_plane),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .blank_req(blank_req), .blank_ack(blank_ack),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_plane(out_plane), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] pixf(input int kind, input int l, input int x);
        case (kind)
            0: return 2'((x + l) & 3);
            1: return 2'(((x * 3) ^ l) & 3);
            2: return 2'd2;
            default: return 2'((((x >> 1) + l * 5)) & 3);
        endcase
    endfunction

    function automatic logic [7:0] expb(input bit mode, input int kind, input logic [3:0] mask,
                                        input bit plane, input int l, input int k);
        logic [7:0] r = 8'h00;
        logic [1:0] v;
        for (int j = 0; j < 8; j++) begin
            int x = k * 8 + j;
            if (x < W) begin
                v = mask[l] ? 2'b11 : pixf(kind, l, x);
                r[7 - j] = plane ? v[0] : (mode ? v[1] : v[0]);
            end
        end
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; pix_valid = 1'b0; pix_data = 2'd0; blank_req = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_frame(input logic [15:0] vec, input bit stall_test);
        bit mode = vec[7];
        bit rnd = vec[6];
        int kind = int'(vec[5:4]);
        logic [3:0] mask = vec[3:0];
        int total = int'(vec[15:8]);
        int pl = 0, px = 0, stall_cnt = 0, sent_at_release = -1, guard = 0;
        int bad_hold = 0, bad_wait = 0, bad_blank = 0, bad_data = 0, bad_plane = 0, bad_last = 0;
        bit released = !stall_test;
        bit prev_hold = 1'b0;
        logic [7:0] prev_data = 8'h00;
        logic prev_plane = 1'b0;
        string dreq;
        @(negedge clk);
        two_plane = mode;
        cap_n = 0;
        while (!wd_hit && guard < 20000) begin
            guard++;
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            blank_req = 1'b0;
            pix_valid = 1'b0;
            if (pl < H) begin
                pix_valid = 1'b1;
                if (mask[pl] && px == 0) begin
                    blank_req = 1'b1;
                    pix_data  = 2'd0;
                end else begin
                    pix_data = pixf(kind, pl, px);
                end
            end
            out_ready = !released ? 1'b0 : (rnd ? lfsr[0] : 1'b1);
            #1;
            if (prev_hold && !(out_valid && out_data == prev_data && out_plane == prev_plane))
                bad_hold++;
            if (mode && pl == H && pix_ready) bad_wait++;
            if (blank_req && blank_ack) begin
                if (pix_ready) bad_blank++;
                pl++; px = 0;
            end else if (pix_valid && pix_ready) begin
                px++;
                if (px == W) begin px = 0; pl++; end
            end
            if (out_valid && out_ready && cap_n < 64) begin
                cap_data[cap_n] = out_data;
                cap_plane[cap_n] = out_plane;
                cap_last[cap_n] = out_last;
                cap_n++;
            end
            if (!released) begin
                if (pl * W + px >= 2 * W && !pix_ready) stall_cnt++;
                if (stall_cnt == 10 || pl * W + px > 2 * W) begin
                    released = 1'b1;
                    sent_at_release = pl * W + px;
                end
            end
            prev_hold  = out_valid && !out_ready;
            prev_data  = out_data;
            prev_plane = out_plane;
            if (pl == H && cap_n >= total) break;
        end
        pix_valid = 1'b0; blank_req = 1'b0;
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        check(pix_ready == 1'b1, "R11 resume", int'(pix_ready), 1);
        check(out_valid == 1'b0 && cap_n == total, "R5 byte count", cap_n, total);
        for (int i = 0; i < total && i < cap_n; i++) begin
            bit pb = (i >= PB);
            int o = pb ? i - PB : i;
            if (cap_data[i] !== expb(mode, kind, mask, pb, o / EMIT, o % EMIT)) bad_data++;
            if (cap_plane[i] !== pb) bad_plane++;
            if (cap_last[i] !== (i == PB - 1 || i == 2 * PB - 1)) bad_last++;
        end
        dreq = mode ? "R2/R3 data" : "R2/R4 data";
        check(bad_data == 0, dreq, bad_data, 0);
        check(bad_plane == 0, "R6 plane order", bad_plane, 0);
        check(bad_last == 0, "R6 end flag", bad_last, 0);
        check(bad_hold == 0, "R8 hold", bad_hold, 0);
        if (mode) check(bad_wait == 0, "R11 hold after frame", bad_wait, 0);
        if (mask != 4'h0) check(bad_blank == 0, "R9 priority", bad_blank, 0);
        if (stall_test) check(sent_at_release == 2 * W && stall_cnt == 10,
                              "R7 stall", sent_at_release, 2 * W);
    endtask

    initial begin
        two_plane = 1'b1;
        do_reset();
        #1;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(pix_ready == 1'b1, "R1 pix_ready", int'(pix_ready), 1);
        check(blank_ack == 1'b0, "R1 blank_ack", int'(blank_ack), 0);

        // R10 latency, one-plane, from reset
        @(negedge clk);
        two_plane = 1'b0;
        out_ready = 1'b0;
        for (int x = 0; x < W && !wd_hit; ) begin
            @(negedge clk);
            pix_valid = 1'b1;
            pix_data  = pixf(0, 0, x);
            #1;
            if (pix_ready) x++;
        end
        @(negedge clk);
        pix_valid = 1'b0;
        #1;
        check(out_valid == 1'b0, "R10 not yet", int'(out_valid), 0);
        @(negedge clk);
        #1;
        check(out_valid == 1'b1, "R10 valid", int'(out_valid), 1);
        check(out_data == expb(1'b0, 0, 4'h0, 1'b0, 0, 0), "R10 first byte",
              int'(out_data), int'(expb(1'b0, 0, 4'h0, 1'b0, 0, 0)));
        do_reset();

        for (int v = 0; v < 6; v++) begin
            run_frame(VEC[v], 1'b0);
            if (v == 4) begin
                check(cap_data[0] == 8'hFF, "R9 blank byte", int'(cap_data[0]), 255);
                check(cap_data[EMIT - 1] == 8'hF0, "R2 tail zero", int'(cap_data[EMIT - 1]), 240);
            end
        end

        run_frame(16'h3090, 1'b1);

        check(!wd_hit, "watchdog", int'(wd_hit), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule